// File: doc/BRIEF.md
# Serial Transmit Holding Stage

This block sits in front of the bit shifter of a buffered synchronous serial transmitter. A bus master loads a 32-bit transmit word as two 16-bit halves. The upper half is written first and only stored. Writing the lower half commits the whole word into a holding stage and marks that stage busy.

Whenever the shifter reports that it is empty and a word is held, the block issues a one-cycle load strobe that carries the word. This frees the holding stage, and the ready flag rises again. A write that lands in the same cycle as a hand-off is kept pending and goes out at the next opportunity, so the ready flag can never stay low with nothing queued. Writes made while the stage is still busy replace the held word and raise a sticky error bit.

An interrupt/request output can follow the ready flag, pulse on every hand-off, or be held quiet. The choice is made by a 2-bit mode input, which lets a master that cannot poll the flag pace its writes.

Top module: `tx_hold_stage`

## Requirements
- R1: After reset, `tx_ready` is 1, `shf_load` is 0 and `tx_ovf` is 0.
- R2: A lower-half write (`wr_en`=1, `wr_lo_sel`=1) makes `tx_ready` 0 from the next cycle on.
- R3: `shf_load` is 1 in exactly the cycles where `tx_ready`=0 and `shf_empty`=1. In that cycle `shf_data` is the held word: bits 31:16 are the last upper-half value and bits 15:0 are the committing lower-half value.
- R4: After a cycle with `shf_load`=1 and no lower-half write, `tx_ready` is 1.
- R5: An upper-half write (`wr_en`=1, `wr_lo_sel`=0) changes neither `tx_ready` nor the held word. It only sets the upper 16 bits used by the next commit.
- R6: A lower-half write in the same cycle as a load strobe sends the older word. The new word stays pending with `tx_ready`=0 and is sent at the next `shf_empty` cycle, after which `tx_ready` returns to 1.
- R7: A lower-half write while `tx_ready`=0 and no load strobe replaces the held word and sets `tx_ovf`.
- R8: `tx_ovf` stays set until a cycle with `ovf_clr`=1. When a new overwrite happens in that same cycle, the bit stays set.
- R9: With `irq_mode`=00, `tx_irq` equals `tx_ready`.
- R10: With `irq_mode`=01, `tx_irq` is 1 exactly in the cycles where `shf_load` is 1.
- R11: With `irq_mode`=10 or 11, `tx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_lo_sel | input | 1 | 1 selects the lower half (commit), 0 selects the upper half |
| wr_data | input | 16 | Write data for the selected half |
| ovf_clr | input | 1 | Write-one strobe that clears the overwrite error |
| irq_mode | input | 2 | Interrupt source select |
| shf_empty | input | 1 | Shifter can accept a word |
| shf_load | output | 1 | One-cycle load strobe to the shifter |
| shf_data | output | 32 | Word handed to the shifter |
| tx_ready | output | 1 | Holding stage free |
| tx_ovf | output | 1 | Sticky overwrite error |
| tx_irq | output | 1 | Transmit interrupt/request |

## Verification
The lower-half commit and the hand-off to the shifter can both happen in one cycle. The bench forces this by holding `shf_empty` high while a word is pending and writing a new lower half in that same cycle. It then judges the result in three ways: the older word must appear on `shf_data`, `tx_ready` must stay low afterwards, and the new word must be delivered on the next empty cycle. A queue model compares every output on every clock. The same model covers random stretches that mix these collisions with overwrites and error clears.

// File: rtl/tx_hold_pkg.sv
package tx_hold_pkg;
   typedef enum logic [1:0] {
      IRQ_READY = 2'b00,
      IRQ_XFER  = 2'b01,
      IRQ_OFF_A = 2'b10,
      IRQ_OFF_B = 2'b11
   } irq_src_e;
endpackage

// File: rtl/tx_hold_regs.sv
module tx_hold_regs #(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_we,
   input  logic              commit,
   input  logic [HALF_W-1:0] wdata,
   output logic [WORD_W-1:0] word_q
);
   logic [HALF_W-1:0] upper_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         word_q  <= '0;
      end else begin
         if (hi_we)  upper_q <= wdata;
         if (commit) word_q  <= {upper_q, wdata};
      end
   end
endmodule

// File: rtl/tx_hold_ctrl.sv
module tx_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic shf_empty,
   input  logic ovf_clr,
   output logic load,
   output logic ready_q,
   output logic ovf_q
);
   logic ovf_set;

   // a word is pending exactly when the stage is not ready
   assign load    = !ready_q && shf_empty;
   assign ovf_set = commit && !ready_q && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
         ovf_q   <= 1'b0;
      end else begin
         if (commit)    ready_q <= 1'b0;  // new word wins over a hand-off
         else if (load) ready_q <= 1'b1;
         if (ovf_set)      ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_irq_sel.sv
module tx_irq_sel
   import tx_hold_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              ready,
   input  logic              load,
   output logic              irq
);
   generate
      if (MODE_W < 2) begin : g_bad
         $error("tx_irq_sel: MODE_W must be at least 2");
      end
   endgenerate

   always_comb begin
      case (irq_src_e'(mode[1:0]))
         IRQ_READY: irq = ready;
         IRQ_XFER:  irq = load;
         default:   irq = 1'b0;
      endcase
   end
endmodule

// File: rtl/tx_hold_stage.sv
module tx_hold_stage #(
   parameter int HALF_W = 16,
   parameter int MODE_W = 2,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_lo_sel,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              ovf_clr,
   input  logic [MODE_W-1:0] irq_mode,
   input  logic              shf_empty,
   output logic              shf_load,
   output logic [WORD_W-1:0] shf_data,
   output logic              tx_ready,
   output logic              tx_ovf,
   output logic              tx_irq
);
   generate
      if (HALF_W < 1) begin : g_bad_w
         $error("tx_hold_stage: HALF_W must be positive");
      end
   endgenerate

   logic commit, hi_we;
   assign commit = wr_en && wr_lo_sel;
   assign hi_we  = wr_en && !wr_lo_sel;

   tx_hold_regs #(.HALF_W(HALF_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .commit(commit),
      .wdata(wr_data), .word_q(shf_data)
   );

   tx_hold_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .commit(commit), .shf_empty(shf_empty),
      .ovf_clr(ovf_clr), .load(shf_load), .ready_q(tx_ready), .ovf_q(tx_ovf)
   );

   tx_irq_sel #(.MODE_W(MODE_W)) u_irq (
      .mode(irq_mode), .ready(tx_ready), .load(shf_load), .irq(tx_irq)
   );
endmodule

// File: rtl/tx_hold_stage_chk.sv
module tx_hold_stage_chk #(
   parameter int HALF_W = 16,
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_lo_sel,
   input logic [HALF_W-1:0] wr_data,
   input logic              ovf_clr,
   input logic [MODE_W-1:0] irq_mode,
   input logic              shf_empty,
   input logic              shf_load,
   input logic [2*HALF_W-1:0] shf_data,
   input logic              tx_ready,
   input logic              tx_ovf,
   input logic              tx_irq
);
   a_r2_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lo_sel) |=> !tx_ready);
   a_r3_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
      shf_load |-> (!tx_ready && shf_empty));
   a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lo_sel) |=> (shf_data[HALF_W-1:0] == $past(wr_data)));
   a_r4_ready_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_load && !(wr_en && wr_lo_sel)) |=> tx_ready);
   a_r5_hi_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_lo_sel) && !shf_load) |=> (tx_ready == $past(tx_ready)));
   a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lo_sel && !tx_ready && !shf_empty) |=> tx_ovf);
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !ovf_clr) |=> tx_ovf);
   a_r9_irq_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode[1:0] == 2'b00) |-> (tx_irq == tx_ready));
   a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode[1:0] == 2'b01) |-> (tx_irq == shf_load));
   a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mode[1] |-> !tx_irq);
endmodule

bind tx_hold_stage tx_hold_stage_chk #(.HALF_W(HALF_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tx_hold_stage_tb.sv
`timescale 1ns/1ps
module tx_hold_stage_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_lo_sel = 1'b0, ovf_clr = 1'b0, shf_empty = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  irq_mode = 2'b00;
   logic        shf_load, tx_ready, tx_ovf, tx_irq;
   logic [31:0] shf_data;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // behavioural model
   logic [31:0] m_q[$];
   logic [15:0] m_hi = '0;
   bit          m_ovf = 1'b0;

   always #2.5 clk = ~clk;

   tx_hold_stage u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo_sel(wr_lo_sel),
      .wr_data(wr_data), .ovf_clr(ovf_clr), .irq_mode(irq_mode),
      .shf_empty(shf_empty), .shf_load(shf_load), .shf_data(shf_data),
      .tx_ready(tx_ready), .tx_ovf(tx_ovf), .tx_irq(tx_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit en, input bit lo, input logic [15:0] d,
                      input bit clr, input bit emp, input logic [1:0] md);
      bit e_ready, e_load, e_irq, commit, ovfset;
      @(negedge clk);
      wr_en = en; wr_lo_sel = lo; wr_data = d; ovf_clr = clr; shf_empty = emp; irq_mode = md;
      #1;
      e_ready = (m_q.size() == 0);
      e_load  = (m_q.size() != 0) && emp;
      case (md)
         2'b00:   e_irq = e_ready;
         2'b01:   e_irq = e_load;
         default: e_irq = 1'b0;
      endcase
      chk(tx_ready === e_ready, "R2/R4/R6 ready", 32'(tx_ready), 32'(e_ready));
      chk(shf_load === e_load, "R3 load", 32'(shf_load), 32'(e_load));
      if (e_load) chk(shf_data === m_q[0], "R3/R5/R6 data", shf_data, m_q[0]);
      chk(tx_irq === e_irq, (md == 2'b00) ? "R9 irq" : (md == 2'b01) ? "R10 irq" : "R11 irq",
          32'(tx_irq), 32'(e_irq));
      chk(tx_ovf === m_ovf, "R7/R8 ovf", 32'(tx_ovf), 32'(m_ovf));
      @(posedge clk);
      commit = en && lo;
      ovfset = commit && (m_q.size() != 0) && !e_load;
      if (e_load) void'(m_q.pop_front());
      if (commit) begin
         if (m_q.size() != 0) void'(m_q.pop_front());
         m_q.push_back({m_hi, d});
      end
      if (en && !lo) m_hi = d;
      if (ovfset) m_ovf = 1'b1;
      else if (clr) m_ovf = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(tx_ready === 1'b1, "R1 ready", 32'(tx_ready), 32'd1);
      chk(tx_ovf === 1'b0, "R1 ovf", 32'(tx_ovf), 32'd0);
      chk(shf_load === 1'b0, "R1 load", 32'(shf_load), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R5 upper half only, then R2 commit while shifter busy
      cyc(1, 0, 16'hA5A5, 0, 0, 2'b00);
      cyc(0, 0, 16'h0,    0, 0, 2'b00);
      cyc(1, 1, 16'h1234, 0, 0, 2'b00);
      cyc(1, 0, 16'hBEEF, 0, 0, 2'b00);  // R5: hi write while pending
      cyc(0, 0, 16'h0,    0, 0, 2'b00);
      // R3/R4 hand-off
      cyc(0, 0, 16'h0,    0, 1, 2'b01);
      cyc(0, 0, 16'h0,    0, 1, 2'b01);
      // R6 collision: commit, then commit again while shifter empty
      cyc(1, 1, 16'h1111, 0, 0, 2'b00);
      cyc(1, 1, 16'h2222, 0, 1, 2'b00);
      cyc(0, 0, 16'h0,    0, 0, 2'b00);
      cyc(0, 0, 16'h0,    0, 1, 2'b01);
      cyc(0, 0, 16'h0,    0, 0, 2'b00);
      // R7 overwrite, R8 sticky and clear
      cyc(1, 1, 16'h3333, 0, 0, 2'b10);
      cyc(1, 1, 16'h4444, 0, 0, 2'b11);
      cyc(0, 0, 16'h0,    0, 0, 2'b10);
      cyc(1, 1, 16'h5555, 1, 0, 2'b00);  // R8: set wins over clear
      cyc(0, 0, 16'h0,    1, 0, 2'b00);
      cyc(0, 0, 16'h0,    0, 1, 2'b00);
      cyc(0, 0, 16'h0,    0, 0, 2'b00);
      // random mix covering R2..R11
      for (int i = 0; i < 3000; i++) begin
         cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom),
             ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule